// File: doc/BRIEF.md
# Exception Dispatch Sequencer

This block chooses which pending exception a processor core services at an instruction boundary, then runs the memory sequence that enters the handler. The core raises `boundary` for one cycle between instructions. The block looks at three sources of requests. Internal trap requests come first, taken from the highest-numbered set bit. Software-posted interrupt levels come next. Interrupt requests from bus devices come last. A software or bus level counts only when it is strictly above the priority field of the current status word.

For the chosen exception the block reads a replacement status word from the vector address plus two. It places the interrupted mode in the previous-mode field of that word, and the result replaces the whole status word. The block then pushes the old status word and the old PC onto the stack, and reads the handler PC from the vector address. When the sequence ends, `done` pulses with the new PC, the new status word and the new stack pointer. In the same cycle the block names the trap bit to clear or the bus level to acknowledge. When nothing qualifies, `noneTaken` pulses and no memory traffic occurs.

Top module: `exc_dispatch`

## Requirements
- R1: Any set bit of `trapReq` beats every interrupt. Among traps the highest set index wins, and trap k uses vector 0x0004 + 4·k. With `done`, `trapClear` holds exactly bit k.
- R2: Software level i (1..7) is pending when `swIntReq[8+i]` is set. It counts only when i exceeds the priority `curPsw[7:5]`, and the highest pending level wins. Every software level uses vector 0x00A0.
- R3: A qualifying software level beats any bus request, whatever the two levels are.
- R4: Bus level i (1..7) is requested when `busReq[i]` is set, with its vector in `busVec[16·i +: 16]`. It counts only when i exceeds the current priority. With `done`, `busAck` holds exactly bit i.
- R5: `wake` pulses together with `done` only for a bus dispatch that was started while `cpuWaiting` was high.
- R6: A `boundary` with no qualifying request pulses `noneTaken` one cycle after the boundary cycle, and no memory request is made.
- R7: The new status word is the word read at vector+2, ORed with `curPsw[15:14]` shifted into bits 13:12.
- R8: Memory order is: read vector+2, write the old status word at SP−2, write the old PC at SP−4, read vector. `newSp` is SP−4 and `newPc` is the word read from the vector.
- R9: One `boundary` dispatches at most one exception. A `boundary` raised while a sequence is running is ignored.
- R10: After reset, `memReq`, `done`, `noneTaken`, `trapClear`, `busAck` and `wake` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction-boundary strobe |
| trapReq | input | NTRAP | Internal trap request mask |
| swIntReq | input | 16 | Software interrupt register (bit 8+i = level i) |
| busReq | input | 8 | Bus interrupt request per level |
| busVec | input | 8·DW | Vector per bus level |
| cpuWaiting | input | 1 | Core is idling until an interrupt |
| curPsw | input | DW | Current status word |
| curPc | input | DW | PC to be saved |
| curSp | input | DW | Current stack pointer |
| memReq | output | 1 | Memory request, held until `memAck` |
| memWe | output | 1 | Write when high |
| memAddr | output | DW | Byte address |
| memWdata | output | DW | Write data |
| memRdata | input | DW | Read data, valid with `memAck` |
| memAck | input | 1 | Transaction complete |
| done | output | 1 | Dispatch finished, results valid |
| noneTaken | output | 1 | Boundary had nothing to dispatch |
| newPc | output | DW | Handler PC |
| newPsw | output | DW | Handler status word |
| newSp | output | DW | Stack pointer after pushes |
| trapClear | output | NTRAP | Serviced trap bit |
| busAck | output | 8 | Acknowledged bus level |
| wake | output | 1 | Return waiting core to running |

## Verification
The hardest situation to reach is a second `boundary` arriving while a dispatch is still in its memory sequence. The bench's memory model stretches every transaction, and a second strobe is raised two cycles into the sequence with the trap still pending. The bench then counts completions over a long window. It also places requests exactly at the current priority level, and pairs software and bus requests so that the bus request has the higher level. Both cases show that the ordering comes from the request class and the strict comparison against the priority, not from the level alone.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;
  typedef enum logic [1:0] {CLS_TRAP, CLS_SW, CLS_BUS} srcClassE;
  typedef enum logic [2:0] {OP_NONE, OP_RDPSW, OP_PUSHPSW, OP_PUSHPC, OP_RDPC} memOpE;
  typedef struct packed {
    logic  latch;
    memOpE op;
    logic  fin;
    logic  none;
  } ctlStrobeS;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_dispatch_pkg::*;
#(
  parameter int DW = 16,
  parameter int NTRAP = 8,
  parameter logic [15:0] TRAP_BASE = 16'h0004,
  parameter logic [15:0] SW_VEC = 16'h00A0,
  localparam int IDX_W = (NTRAP > 8) ? $clog2(NTRAP) : 3
) (
  input  logic [NTRAP-1:0] trapReq,
  input  logic [15:0]      swIntReq,
  input  logic [7:0]       busReq,
  input  logic [8*DW-1:0]  busVec,
  input  logic [2:0]       curPrio,
  output logic             found,
  output srcClassE         cls,
  output logic [IDX_W-1:0] idx,
  output logic [DW-1:0]    vector
);
  // Later loops override earlier ones: bus < software < trap.
  // Inside each loop ascending order lets the highest index win.
  always_comb begin
    found  = 1'b0;
    cls    = CLS_TRAP;
    idx    = '0;
    vector = '0;
    for (int l = 1; l < 8; l++) begin
      if (busReq[l] && (l > 32'(curPrio))) begin
        found  = 1'b1;
        cls    = CLS_BUS;
        idx    = IDX_W'(l);
        vector = busVec[l*DW +: DW];
      end
    end
    for (int l = 1; l < 8; l++) begin
      if (swIntReq[8+l] && (l > 32'(curPrio))) begin
        found  = 1'b1;
        cls    = CLS_SW;
        idx    = IDX_W'(l);
        vector = DW'(SW_VEC);
      end
    end
    for (int t = 0; t < NTRAP; t++) begin
      if (trapReq[t]) begin
        found  = 1'b1;
        cls    = CLS_TRAP;
        idx    = IDX_W'(t);
        vector = DW'(TRAP_BASE) + DW'(4 * t);
      end
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_dispatch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      boundary,
  input  logic      found,
  input  logic      memAck,
  output logic      memReq,
  output logic      memWe,
  output ctlStrobeS ctl
);
  typedef enum logic [2:0] {S_IDLE, S_RDPSW, S_PUSHPSW, S_PUSHPC, S_RDPC, S_FIN, S_NONE} stateE;
  stateE state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:    if (boundary) stateNext = found ? S_RDPSW : S_NONE;
      S_RDPSW:   if (memAck) stateNext = S_PUSHPSW;
      S_PUSHPSW: if (memAck) stateNext = S_PUSHPC;
      S_PUSHPC:  if (memAck) stateNext = S_RDPC;
      S_RDPC:    if (memAck) stateNext = S_FIN;
      S_FIN:     stateNext = S_IDLE;
      S_NONE:    stateNext = S_IDLE;
      default:   stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.latch = (state == S_IDLE) && boundary && found;
    ctl.fin   = (state == S_FIN);
    ctl.none  = (state == S_NONE);
    unique case (state)
      S_RDPSW:   ctl.op = OP_RDPSW;
      S_PUSHPSW: ctl.op = OP_PUSHPSW;
      S_PUSHPC:  ctl.op = OP_PUSHPC;
      S_RDPC:    ctl.op = OP_RDPC;
      default:   ctl.op = OP_NONE;
    endcase
  end

  assign memReq = (ctl.op != OP_NONE);
  assign memWe  = (ctl.op == OP_PUSHPSW) || (ctl.op == OP_PUSHPC);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fin |=> !ctl.fin && !memReq);
  assert_busy_ignores_boundary_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && boundary) |=> (memReq || ctl.fin));
  assert_none_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.none |-> !memReq && !$past(memReq));
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_dispatch_pkg::*;
#(
  parameter int DW = 16,
  parameter int NTRAP = 8,
  localparam int IDX_W = (NTRAP > 8) ? $clog2(NTRAP) : 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobeS        ctl,
  input  srcClassE         selCls,
  input  logic [IDX_W-1:0] selIdx,
  input  logic [DW-1:0]    selVec,
  input  logic             cpuWaiting,
  input  logic [DW-1:0]    curPsw,
  input  logic [DW-1:0]    curPc,
  input  logic [DW-1:0]    curSp,
  input  logic             memReq,
  input  logic             memWe,
  input  logic             memAck,
  input  logic [DW-1:0]    memRdata,
  output logic [DW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  output logic [DW-1:0]    newPc,
  output logic [DW-1:0]    newPsw,
  output logic [DW-1:0]    newSp,
  output logic [NTRAP-1:0] trapClear,
  output logic [7:0]       busAck,
  output logic             wake
);
  logic [DW-1:0]    vecReg, oldPsw, oldPc, spWork;
  srcClassE         clsReg;
  logic [IDX_W-1:0] idxReg;
  logic             waitReg;
  logic [DW-1:0]    spDec;

  assign spDec = spWork - DW'(2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg <= '0; oldPsw <= '0; oldPc <= '0; spWork <= '0;
      clsReg <= CLS_TRAP; idxReg <= '0; waitReg <= 1'b0;
      newPc <= '0; newPsw <= '0;
    end else begin
      if (ctl.latch) begin
        vecReg  <= selVec;
        oldPsw  <= curPsw;
        oldPc   <= curPc;
        spWork  <= curSp;
        clsReg  <= selCls;
        idxReg  <= selIdx;
        waitReg <= cpuWaiting;
      end
      if (memAck) begin
        unique case (ctl.op)
          OP_RDPSW:   newPsw <= memRdata | (DW'(oldPsw[15:14]) << 12);
          OP_PUSHPSW: spWork <= spDec;
          OP_PUSHPC:  spWork <= spDec;
          OP_RDPC:    newPc  <= memRdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    unique case (ctl.op)
      OP_RDPSW:   memAddr = vecReg + DW'(2);
      OP_PUSHPSW: begin memAddr = spDec; memWdata = oldPsw; end
      OP_PUSHPC:  begin memAddr = spDec; memWdata = oldPc;  end
      OP_RDPC:    memAddr = vecReg;
      default: ;
    endcase
  end

  assign newSp = spWork;

  for (genvar t = 0; t < NTRAP; t++) begin : g_trapClr
    assign trapClear[t] = ctl.fin && (clsReg == CLS_TRAP) && (idxReg == IDX_W'(t));
  end
  for (genvar l = 0; l < 8; l++) begin : g_busAck
    assign busAck[l] = ctl.fin && (clsReg == CLS_BUS) && (idxReg == IDX_W'(l));
  end
  assign wake = ctl.fin && (clsReg == CLS_BUS) && waitReg;

  assert_pc_read_after_push_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck && memWdata == oldPc) |=> (memReq && !memWe && memAddr == vecReg));
  assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trapClear, busAck}));
  assert_wake_only_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> ctl.fin && $onehot(busAck));
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_dispatch_pkg::*;
#(
  parameter int DW = 16,
  parameter int NTRAP = 8,
  parameter logic [15:0] TRAP_BASE = 16'h0004,
  parameter logic [15:0] SW_VEC = 16'h00A0,
  localparam int IDX_W = (NTRAP > 8) ? $clog2(NTRAP) : 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             boundary,
  input  logic [NTRAP-1:0] trapReq,
  input  logic [15:0]      swIntReq,
  input  logic [7:0]       busReq,
  input  logic [8*DW-1:0]  busVec,
  input  logic             cpuWaiting,
  input  logic [DW-1:0]    curPsw,
  input  logic [DW-1:0]    curPc,
  input  logic [DW-1:0]    curSp,
  output logic             memReq,
  output logic             memWe,
  output logic [DW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  input  logic [DW-1:0]    memRdata,
  input  logic             memAck,
  output logic             done,
  output logic             noneTaken,
  output logic [DW-1:0]    newPc,
  output logic [DW-1:0]    newPsw,
  output logic [DW-1:0]    newSp,
  output logic [NTRAP-1:0] trapClear,
  output logic [7:0]       busAck,
  output logic             wake
);
  ctlStrobeS        ctl;
  logic             found;
  srcClassE         selCls;
  logic [IDX_W-1:0] selIdx;
  logic [DW-1:0]    selVec;

  exc_arbiter #(.DW(DW), .NTRAP(NTRAP), .TRAP_BASE(TRAP_BASE), .SW_VEC(SW_VEC)) i_arb (
    .trapReq(trapReq), .swIntReq(swIntReq), .busReq(busReq), .busVec(busVec),
    .curPrio(curPsw[7:5]), .found(found), .cls(selCls), .idx(selIdx), .vector(selVec));

  exc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .found(found), .memAck(memAck),
    .memReq(memReq), .memWe(memWe), .ctl(ctl));

  exc_datapath #(.DW(DW), .NTRAP(NTRAP)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .selCls(selCls), .selIdx(selIdx), .selVec(selVec),
    .cpuWaiting(cpuWaiting), .curPsw(curPsw), .curPc(curPc), .curSp(curSp),
    .memReq(memReq), .memWe(memWe), .memAck(memAck), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .newPc(newPc), .newPsw(newPsw), .newSp(newSp),
    .trapClear(trapClear), .busAck(busAck), .wake(wake));

  assign done      = ctl.fin;
  assign noneTaken = ctl.none;
endmodule

// File: tb/test_exc_dispatch.sv
module test_exc_dispatch;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, boundary, cpuWaiting, memAck, memReq, memWe;
  logic done, noneTaken, wake;
  logic [7:0] trapReq, busReq, trapClear, busAck;
  logic [15:0] swIntReq, curPsw, curPc, curSp, memAddr, memWdata, memRdata;
  logic [15:0] newPc, newPsw, newSp;
  logic [127:0] busVec;

  exc_dispatch i_exc_dispatch (
    .clk(clk), .rstN(rstN), .boundary(boundary), .trapReq(trapReq), .swIntReq(swIntReq),
    .busReq(busReq), .busVec(busVec), .cpuWaiting(cpuWaiting), .curPsw(curPsw),
    .curPc(curPc), .curSp(curSp), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .done(done),
    .noneTaken(noneTaken), .newPc(newPc), .newPsw(newPsw), .newSp(newSp),
    .trapClear(trapClear), .busAck(busAck), .wake(wake));

  int nChecks = 0, nFails = 0;
  logic [15:0] memArr [0:255];
  logic [15:0] logAddr [0:7];
  logic        logWe [0:7];
  logic [15:0] logData [0:7];
  int logCnt = 0;

  // Memory model: acknowledges each request on the following falling edge.
  always @(negedge clk) begin
    if (memReq && !memAck) begin
      memAck   <= 1'b1;
      memRdata <= memArr[memAddr[8:1]];
      if (logCnt < 8) begin
        logAddr[logCnt] = memAddr; logWe[logCnt] = memWe; logData[logCnt] = memWdata;
      end
      logCnt = logCnt + 1;
      if (memWe) memArr[memAddr[8:1]] <= memWdata;
    end else begin
      memAck <= 1'b0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Raise one boundary and wait for done or noneTaken; result: 1 done, 2 none, 0 timeout.
  task automatic dispatch(output int res);
    logCnt = 0;
    @(negedge clk); boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
    res = 0;
    for (int c = 0; c < 60; c++) begin
      if (done) begin res = 1; break; end
      if (noneTaken) begin res = 2; break; end
      @(negedge clk);
    end
  endtask

  task automatic clearReqs();
    trapReq = '0; swIntReq = '0; busReq = '0; cpuWaiting = 1'b0;
  endtask

  task automatic checkSequence(string req, logic [15:0] vec, logic [15:0] sp,
                               logic [15:0] psw, logic [15:0] pc);
    check(req, logCnt, 4);
    check(req, {logWe[0], logAddr[0]}, {1'b0, vec + 16'd2});
    check(req, {logWe[1], logAddr[1], logData[1]}, {1'b1, sp - 16'd2, psw});
    check(req, {logWe[2], logAddr[2], logData[2]}, {1'b1, sp - 16'd4, pc});
    check(req, {logWe[3], logAddr[3]}, {1'b0, vec});
    check(req, newSp, sp - 16'd4);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R10 reset outputs", {memReq, done, noneTaken, wake, trapClear, busAck}, '0);
  endtask

  task automatic testTrap();
    int res;
    clearReqs();
    trapReq = 8'b0010_0100; swIntReq = 16'h8000; busReq = 8'h80;
    curPsw = 16'hC000; curPc = 16'h1234; curSp = 16'h01F0;
    memArr[8'h0D] = 16'h00E0;  // vector 0x18 + 2
    memArr[8'h0C] = 16'h0400;  // vector 0x18
    dispatch(res);
    check("R1 trap done", res, 1);
    check("R1 trapClear", trapClear, 8'h20);
    check("R1 busAck low", busAck, 8'h00);
    check("R7 new psw mode", newPsw, 16'h30E0);
    check("R8 new pc", newPc, 16'h0400);
    checkSequence("R8 order", 16'h0018, 16'h01F0, 16'hC000, 16'h1234);
  endtask

  task automatic testSoftware();
    int res;
    clearReqs();
    swIntReq = 16'h2400;  // levels 5 and 2
    busReq = 8'h80; busVec[7*16 +: 16] = 16'h00C0;
    curPsw = 16'h4060; curPc = 16'h2000; curSp = 16'h0180;  // priority 3, mode 1
    memArr[8'h51] = 16'h0005; memArr[8'h50] = 16'h0700;
    dispatch(res);
    check("R3 software beats higher bus", res, 1);
    check("R3 no busAck", busAck, 8'h00);
    check("R2 software vector pc", newPc, 16'h0700);
    check("R7 software psw", newPsw, 16'h1005);
    checkSequence("R2 order", 16'h00A0, 16'h0180, 16'h4060, 16'h2000);
    clearReqs();
    swIntReq = 16'h0C00;  // levels 3 and 2 at/below priority 3
    dispatch(res);
    check("R2 levels not above priority ignored", res, 2);
    check("R6 no memory traffic", logCnt, 0);
  endtask

  task automatic testBus();
    int res;
    clearReqs();
    busReq = 8'h48; cpuWaiting = 1'b1;  // levels 6 and 3
    busVec[6*16 +: 16] = 16'h00C4; busVec[3*16 +: 16] = 16'h0030;
    curPsw = 16'h0080; curPc = 16'h3000; curSp = 16'h0100;  // priority 4
    memArr[8'h63] = 16'h00A0; memArr[8'h62] = 16'h0900;
    dispatch(res);
    check("R4 bus done", res, 1);
    check("R4 busAck level 6", busAck, 8'h40);
    check("R5 wake with bus", wake, 1'b1);
    check("R4 bus pc", newPc, 16'h0900);
    check("R1 no trapClear", trapClear, 8'h00);
    clearReqs();
    busReq = 8'h10; curPsw = 16'h0080;  // level 4 equals priority
    dispatch(res);
    check("R4 level at priority ignored", res, 2);
    clearReqs();
    busReq = 8'h40; cpuWaiting = 1'b0;
    dispatch(res);
    check("R5 no wake when running", {res[1:0], wake}, {2'd1, 1'b0});
    clearReqs();
    trapReq = 8'h01; cpuWaiting = 1'b1;
    memArr[8'h03] = 16'h0000; memArr[8'h02] = 16'h0600;
    dispatch(res);
    check("R5 no wake for trap", {res[1:0], wake, trapClear}, {2'd1, 1'b0, 8'h01});
  endtask

  task automatic testBusy();
    int nDone = 0, nNone = 0;
    clearReqs();
    trapReq = 8'h02; curPsw = 16'h0000; curSp = 16'h01C0;
    logCnt = 0;
    @(negedge clk); boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
    @(negedge clk); boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (done) nDone++;
      if (noneTaken) nNone++;
      @(negedge clk);
    end
    check("R9 one dispatch per boundary", nDone, 1);
    check("R9 no extra none", nNone, 0);
    check("R9 four transactions", logCnt, 4);
  endtask

  task automatic testNone();
    int res;
    clearReqs();
    dispatch(res);
    check("R6 none taken", res, 2);
    check("R6 no memory", logCnt, 0);
    @(negedge clk);
    check("R6 none is a pulse", noneTaken, 1'b0);
  endtask

  initial begin
    rstN = 1'b0; boundary = 1'b0; memAck = 1'b0; memRdata = '0;
    busVec = '0; curPsw = '0; curPc = '0; curSp = '0;
    clearReqs();
    for (int i = 0; i < 256; i++) memArr[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTrap();
    testSoftware();
    testBus();
    testBusy();
    testNone();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule